// File: doc/BRIEF.md
# Two-Way Page Descriptor Cache

This block keeps recently used page descriptors close to the address translation path of a segmented, paged memory management unit. The descriptor array is split into sections. A row is picked by scaling the section number taken from the virtual address by the number of rows per section and then adding the page index field. Every row has two entries, left and right. Each entry holds a tag word and a descriptor word.

A lookup is purely combinational. It reports hit or miss, which side hit, the descriptor, the physical page address and the access-permission byte. A fill installs a descriptor on the next clock edge. It prefers empty entries, and when both entries are full it uses a single history bit kept in the left descriptor word. A section flush invalidates both entries of every row in one section.

Top module: `pdc_cache`

## Requirements
- R1: With default parameters the virtual address splits into section ID = va[31:30], page index = va[13:11] and tag = va[29:14]. The row used is section ID * 8 + page index.
- R2: After reset every entry is invalid, so every lookup misses and reports a zero descriptor and a zero access byte.
- R3: The stored descriptor keeps bits 31:11, 5, 4 and 1 of the filled value, forces bit 0 (valid) to 1 and holds every other bit at 0. On a hit the lookup returns that word, the physical page address (bits 31:11) and the access byte. The access byte sits in bits 31:24 of the tag word and the tag in its low 16 bits.
- R4: A fill into a row whose left entry is invalid writes the left entry and clears the history bit.
- R5: A fill into a row whose left entry is valid and right entry is invalid writes the right entry and sets the history bit.
- R6: A fill into a row with both entries valid writes the right entry and sets the history bit when the bit is 0. When the bit is 1 it writes the left entry and clears the bit. The history bit is held at bit 6 of the left descriptor word, is never written into a tag word and never shows in a lookup result.
- R7: A flush of section S clears the valid bit of both entries in all rows of S, including the last section. It leaves the rows of other sections and the history bits unchanged.
- R8: When a flush and a fill arrive in the same cycle, only the flush takes effect.
- R9: A lookup hits when a valid entry of the row has a matching tag. If both entries match, the left one is returned. The output lk_right is 1 only when the right entry supplied the hit.
- R10: A lookup reflects fills and flushes from the next clock edge on. The lookup path itself has no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_right | output | 1 | Hit came from the right entry |
| lk_desc | output | 32 | Descriptor word on hit, else 0 |
| lk_ppa | output | 21 | Physical page address (descriptor bits 31:11) |
| lk_acc | output | 8 | Access-permission byte on hit, else 0 |
| fill_en | input | 1 | Install a descriptor |
| fill_va | input | 32 | Virtual address of the descriptor to install |
| fill_pd | input | 32 | Descriptor to install |
| fill_acc | input | 8 | Access-permission byte to install |
| flush_en | input | 1 | Invalidate one section |
| flush_sec | input | 2 | Section to invalidate |

## Verification
A wrong history bit does not show at the ports right away. It shows on the third or a later fill into the same full row, because that fill evicts the wrong side: one cycle later the expected descriptor misses while the evicted one still hits, or lk_right flips. A flush that indexes the wrong rows shows on the lookup one cycle after the flush. Either a stale descriptor in the flushed section still hits, or a descriptor in a neighbouring section is lost. The history bit leaking into a tag word turns later lookups of a left entry into misses. For that reason the bench checks random addresses from a small tag pool after every operation, so that rows fill, evict and collide often.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int TAG_W      = 16;
  localparam int VALID_BIT  = 0;
  localparam int HIST_BIT   = 6;
  localparam int ACC_LSB    = 24;
  localparam logic [31:0] KEEP_MASK = 32'hFFFF_F832;

  // Descriptor word as it is held in an entry: valid forced, history clear.
  function automatic logic [31:0] pack_desc(input logic [31:0] pd);
    return (pd & KEEP_MASK) | 32'h1;
  endfunction

  // Tag word: access byte high, address tag low, nothing in between.
  function automatic logic [31:0] pack_tag(input logic [TAG_W-1:0] tag,
                                           input logic [7:0] acc);
    return {acc, 8'h00, tag};
  endfunction
endpackage

// File: rtl/pdc_victim.sv
module pdc_victim (
  input  logic l_valid,
  input  logic r_valid,
  input  logic hist,
  output logic pick_right
);
  always_comb begin
    if (!l_valid)      pick_right = 1'b0;
    else if (!r_valid) pick_right = 1'b1;
    else               pick_right = !hist;
  end
endmodule

// File: rtl/pdc_store.sv
module pdc_store #(
  parameter int SEC_W = 2,
  parameter int IDX_W = 3,
  localparam int RW   = SEC_W + IDX_W,
  localparam int ROWS = 1 << RW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_en,
  input  logic [SEC_W-1:0] flush_sec,
  input  logic             fill_go,
  input  logic [RW-1:0]    fill_row,
  input  logic             pick_right,
  input  logic [31:0]      new_tag,
  input  logic [31:0]      new_desc,
  input  logic [RW-1:0]    lk_row,
  output logic [31:0]      lk_ltag,
  output logic [31:0]      lk_ldesc,
  output logic [31:0]      lk_rtag,
  output logic [31:0]      lk_rdesc,
  output logic [31:0]      f_ldesc,
  output logic [31:0]      f_rdesc
);
  import pdc_pkg::*;

  logic [31:0] ltag [ROWS];
  logic [31:0] ldesc[ROWS];
  logic [31:0] rtag [ROWS];
  logic [31:0] rdesc[ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam logic [SEC_W-1:0] ROW_SEC = SEC_W'(r >> IDX_W);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ltag[r]  <= '0;
        ldesc[r] <= '0;
        rtag[r]  <= '0;
        rdesc[r] <= '0;
      end else if (flush_en && flush_sec == ROW_SEC) begin
        ldesc[r][VALID_BIT] <= 1'b0;
        rdesc[r][VALID_BIT] <= 1'b0;
      end else if (fill_go && fill_row == RW'(r)) begin
        if (pick_right) begin
          rtag[r]            <= new_tag;
          rdesc[r]           <= new_desc;
          ldesc[r][HIST_BIT] <= 1'b1;
        end else begin
          ltag[r]  <= new_tag;
          ldesc[r] <= new_desc & ~(32'h1 << HIST_BIT);
        end
      end
    end
  end

  assign lk_ltag  = ltag[lk_row];
  assign lk_ldesc = ldesc[lk_row];
  assign lk_rtag  = rtag[lk_row];
  assign lk_rdesc = rdesc[lk_row];
  assign f_ldesc  = ldesc[fill_row];
  assign f_rdesc  = rdesc[fill_row];

  a_r4_left_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go && !pick_right |=>
      ldesc[$past(fill_row)][VALID_BIT] && !ldesc[$past(fill_row)][HIST_BIT]);

  a_r5_right_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go && pick_right |=>
      rdesc[$past(fill_row)][VALID_BIT] && ldesc[$past(fill_row)][HIST_BIT]);

  a_r6_tag_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go && pick_right |=> ltag[$past(fill_row)] == $past(f_ltag_w));

  logic [31:0] f_ltag_w;
  assign f_ltag_w = ltag[fill_row];
endmodule

// File: rtl/pdc_match.sv
module pdc_match (
  input  logic [15:0] tag,
  input  logic [31:0] ltag,
  input  logic [31:0] ldesc,
  input  logic [31:0] rtag,
  input  logic [31:0] rdesc,
  output logic        hit,
  output logic        right,
  output logic [31:0] desc,
  output logic [7:0]  acc
);
  import pdc_pkg::*;

  logic l_hit, r_hit;
  assign l_hit = ldesc[VALID_BIT] && ltag[TAG_W-1:0] == tag;
  assign r_hit = rdesc[VALID_BIT] && rtag[TAG_W-1:0] == tag;

  always_comb begin
    hit   = l_hit | r_hit;
    right = !l_hit && r_hit;
    desc  = '0;
    acc   = '0;
    if (l_hit) begin
      desc = ldesc & ~(32'h1 << HIST_BIT);
      acc  = ltag[ACC_LSB +: 8];
    end else if (r_hit) begin
      desc = rdesc & ~(32'h1 << HIST_BIT);
      acc  = rtag[ACC_LSB +: 8];
    end
  end
endmodule

// File: rtl/pdc_cache.sv
module pdc_cache #(
  parameter int SEC_W    = 2,
  parameter int IDX_W    = 3,
  parameter int PAGE_LSB = 11,
  localparam int RW      = SEC_W + IDX_W,
  localparam int TAG_LSB = PAGE_LSB + IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      lk_va,
  output logic             lk_hit,
  output logic             lk_right,
  output logic [31:0]      lk_desc,
  output logic [20:0]      lk_ppa,
  output logic [7:0]       lk_acc,
  input  logic             fill_en,
  input  logic [31:0]      fill_va,
  input  logic [31:0]      fill_pd,
  input  logic [7:0]       fill_acc,
  input  logic             flush_en,
  input  logic [SEC_W-1:0] flush_sec
);
  import pdc_pkg::*;

  function automatic logic [SEC_W-1:0] va_sec(input logic [31:0] va);
    return va[31 -: SEC_W];
  endfunction

  function automatic logic [RW-1:0] va_row(input logic [31:0] va);
    return RW'(va_sec(va)) * RW'(1 << IDX_W) + RW'(va[PAGE_LSB +: IDX_W]);
  endfunction

  function automatic logic [TAG_W-1:0] va_tag(input logic [31:0] va);
    return va[TAG_LSB +: TAG_W];
  endfunction

  // named internal events
  logic           fill_go;
  logic [RW-1:0]  fill_row, lk_row;
  logic           pick_right;
  logic [SEC_W-1:0] lk_sec;
  logic [31:0]    lk_ltag, lk_ldesc, lk_rtag, lk_rdesc, f_ldesc, f_rdesc;

  assign fill_go  = fill_en && !flush_en;
  assign fill_row = va_row(fill_va);
  assign lk_row   = va_row(lk_va);
  assign lk_sec   = va_sec(lk_va);

  pdc_victim u_victim (
    .l_valid    (f_ldesc[VALID_BIT]),
    .r_valid    (f_rdesc[VALID_BIT]),
    .hist       (f_ldesc[HIST_BIT]),
    .pick_right (pick_right)
  );

  pdc_store #(.SEC_W(SEC_W), .IDX_W(IDX_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_en   (flush_en),
    .flush_sec  (flush_sec),
    .fill_go    (fill_go),
    .fill_row   (fill_row),
    .pick_right (pick_right),
    .new_tag    (pack_tag(va_tag(fill_va), fill_acc)),
    .new_desc   (pack_desc(fill_pd)),
    .lk_row     (lk_row),
    .lk_ltag    (lk_ltag),
    .lk_ldesc   (lk_ldesc),
    .lk_rtag    (lk_rtag),
    .lk_rdesc   (lk_rdesc),
    .f_ldesc    (f_ldesc),
    .f_rdesc    (f_rdesc)
  );

  pdc_match u_match (
    .tag   (va_tag(lk_va)),
    .ltag  (lk_ltag),
    .ldesc (lk_ldesc),
    .rtag  (lk_rtag),
    .rdesc (lk_rdesc),
    .hit   (lk_hit),
    .right (lk_right),
    .desc  (lk_desc),
    .acc   (lk_acc)
  );

  assign lk_ppa = lk_desc[31:11];

  // R7: the cycle after a flush, nothing in that section can hit
  a_r7_flushed_miss: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en |=> (lk_sec != $past(flush_sec)) || !lk_hit);

  // R3: a hit always carries a valid descriptor with history hidden
  a_r3_hit_desc: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_desc[VALID_BIT] && !lk_desc[HIST_BIT]);
endmodule

// File: tb/sim_pdc_cache.sv
module sim_pdc_cache;
  logic        clk = 0, rst_n = 0;
  logic [31:0] lk_va = 0, fill_va = 0, fill_pd = 0;
  logic [7:0]  fill_acc = 0;
  logic        fill_en = 0, flush_en = 0;
  logic [1:0]  flush_sec = 0;
  logic        lk_hit, lk_right;
  logic [31:0] lk_desc;
  logic [20:0] lk_ppa;
  logic [7:0]  lk_acc;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pdc_cache u0 (.clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit),
    .lk_right(lk_right), .lk_desc(lk_desc), .lk_ppa(lk_ppa), .lk_acc(lk_acc),
    .fill_en(fill_en), .fill_va(fill_va), .fill_pd(fill_pd), .fill_acc(fill_acc),
    .flush_en(flush_en), .flush_sec(flush_sec));

  // reference model
  bit        m_lv[32], m_rv[32], m_h[32];
  bit [15:0] m_lt[32], m_rt[32];
  bit [31:0] m_lp[32], m_rp[32];
  bit [7:0]  m_la[32], m_ra[32];

  function automatic int row_of(bit [31:0] va);
    return int'(va[31:30]) * 8 + int'(va[13:11]);
  endfunction
  function automatic bit [15:0] tag_of(bit [31:0] va); return va[29:14]; endfunction
  function automatic bit [31:0] held(bit [31:0] pd);
    return {pd[31:11], 5'b0, pd[5], pd[4], 2'b0, pd[1], 1'b1};
  endfunction

  function automatic void m_fill(bit [31:0] va, bit [31:0] pd, bit [7:0] acc);
    int r = row_of(va);
    bit go_right = m_lv[r] && (!m_rv[r] || !m_h[r]);
    if (go_right) begin
      m_rv[r] = 1; m_rt[r] = tag_of(va); m_rp[r] = held(pd); m_ra[r] = acc; m_h[r] = 1;
    end else begin
      m_lv[r] = 1; m_lt[r] = tag_of(va); m_lp[r] = held(pd); m_la[r] = acc; m_h[r] = 0;
    end
  endfunction

  function automatic void m_flush(bit [1:0] s);
    for (int i = 0; i < 8; i++) begin m_lv[s*8+i] = 0; m_rv[s*8+i] = 0; end
  endfunction

  task automatic op(bit fe, bit [31:0] va, bit [31:0] pd, bit [7:0] acc,
                    bit xe, bit [1:0] s);
    @(negedge clk);
    fill_en = fe; fill_va = va; fill_pd = pd; fill_acc = acc;
    flush_en = xe; flush_sec = s;
    @(posedge clk);
    if (xe) m_flush(s); else if (fe) m_fill(va, pd, acc);
    #1 fill_en = 0; flush_en = 0;
  endtask

  task automatic probe(bit [31:0] va, string req);
    int r = row_of(va);
    bit lh = m_lv[r] && m_lt[r] == tag_of(va);
    bit rh = m_rv[r] && m_rt[r] == tag_of(va);
    bit eh = lh || rh, er = !lh && rh;
    bit [31:0] ed = lh ? m_lp[r] : rh ? m_rp[r] : 0;
    bit [7:0]  ea = lh ? m_la[r] : rh ? m_ra[r] : 0;
    @(negedge clk);
    lk_va = va;
    #1;
    checks++;
    if (lk_hit !== eh || lk_right !== er || lk_desc !== ed || lk_acc !== ea
        || lk_ppa !== ed[31:11]) begin
      fails++;
      $display("FAIL %s va=%h got hit=%b right=%b desc=%h acc=%h exp hit=%b right=%b desc=%h acc=%h",
               req, va, lk_hit, lk_right, lk_desc, lk_acc, eh, er, ed, ea);
    end
  endtask

  function automatic bit [31:0] mkva(bit [1:0] s, bit [2:0] i, bit [15:0] t);
    return {s, t, i, 11'h0};
  endfunction

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R2: reset state
    probe(mkva(0, 0, 16'h0000), "R2");
    probe(mkva(3, 7, 16'h0000), "R2");
    // R1/R4: empty row goes left; R10 visible after the edge
    op(1, mkva(1, 5, 16'hA), 32'hFFFF_FFFF, 8'h5A, 0, 0);
    probe(mkva(1, 5, 16'hA), "R4 R3 R10");
    probe(mkva(1, 4, 16'hA), "R1");
    probe(mkva(2, 5, 16'hA), "R1");
    // R5: left valid, right empty
    op(1, mkva(1, 5, 16'hB), 32'h1234_5678, 8'h11, 0, 0);
    probe(mkva(1, 5, 16'hB), "R5");
    probe(mkva(1, 5, 16'hA), "R6 tag word intact");
    // R6: full, history 1 -> left
    op(1, mkva(1, 5, 16'hC), 32'h8000_0830, 8'h22, 0, 0);
    probe(mkva(1, 5, 16'hA), "R6 evict left");
    probe(mkva(1, 5, 16'hC), "R6");
    // R6: full, history 0 -> right
    op(1, mkva(1, 5, 16'hD), 32'h0000_0802, 8'h33, 0, 0);
    probe(mkva(1, 5, 16'hB), "R6 evict right");
    probe(mkva(1, 5, 16'hD), "R6");
    // R9: duplicate tag in both entries, left wins
    op(1, mkva(0, 2, 16'h7), 32'h1111_1000, 8'h01, 0, 0);
    op(1, mkva(0, 2, 16'h7), 32'h2222_2000, 8'h02, 0, 0);
    probe(mkva(0, 2, 16'h7), "R9");
    // R7: flush of last section, neighbours untouched
    op(1, mkva(3, 7, 16'h9), 32'h3333_3000, 8'h03, 0, 0);
    op(1, mkva(2, 7, 16'h9), 32'h4444_4000, 8'h04, 0, 0);
    op(0, 0, 0, 0, 1, 3);
    probe(mkva(3, 7, 16'h9), "R7");
    probe(mkva(2, 7, 16'h9), "R7 other section");
    probe(mkva(0, 2, 16'h7), "R7 other section");
    // R8: flush and fill together
    op(1, mkva(2, 0, 16'h4), 32'h5555_5000, 8'h05, 1, 1);
    probe(mkva(2, 0, 16'h4), "R8");
    probe(mkva(1, 5, 16'hD), "R8 flushed");
    // random mix
    void'($urandom(32'h5EED));
    for (int n = 0; n < 3000; n++) begin
      int k = $urandom_range(0, 19);
      bit [31:0] va = mkva(2'($urandom), 3'($urandom_range(0, 3)), 16'($urandom_range(0, 5)));
      if (k == 0)      op(0, 0, 0, 0, 1, 2'($urandom));
      else if (k == 1) op(1, va, $urandom, 8'($urandom), 1, 2'($urandom));
      else if (k < 11) op(1, va, $urandom, 8'($urandom), 0, 0);
      probe(mkva(2'($urandom), 3'($urandom_range(0, 3)), 16'($urandom_range(0, 5))),
            "R3 R6 R9 random");
      probe(va, "R4 R5 R6 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule